// File: doc/BRIEF.md
# Parallel-to-Serial Word Shifter

This block takes a parallel word (five bits by default) and drives it onto a single serial line, one bit per rising clock edge, lowest index first. A producer presents the word together with a valid flag. When the shifter is idle and sees the flag high on a rising edge, it captures the word and drives bit 0 on that same edge. It then drives the remaining bits on the edges that follow.

A busy flag marks every cycle in which the line carries a real data bit. A one-cycle end-of-word flag marks the cycle in which the last bit is on the line. If the producer holds the valid flag high in that cycle, the next word is captured on the following edge, so the line streams with no gap. The word is held in an internal register, so the parallel input may change freely once the word has been captured. Every output is driven straight from a flip-flop. Reset is synchronous.

Top module: `ser5_serializer`

## Requirements
- R1: While reset is sampled high on a rising edge, the outputs `ser_o`, `busy_o` and `last_o` are low after that edge. A word that is in progress when reset arrives is abandoned.
- R2: Suppose the block is idle (`busy_o` low) and `valid_i` is high on a rising edge. After that edge, `busy_o` is high and `ser_o` equals bit 0 of the `data_i` value sampled on that edge. No idle cycle is inserted.
- R3: The bits of a captured word appear on `ser_o` in index order. Bit k is driven in the k-th cycle after the capture edge, for k from 0 to WIDTH-1.
- R4: `busy_o` is high in every one of the WIDTH cycles of a word.
- R5: `last_o` is high only in the cycle in which bit WIDTH-1 is on `ser_o`. It is high for exactly one cycle per word, and only while `busy_o` is high.
- R6: If `valid_i` is high in the cycle in which `last_o` is high, the next edge captures a new word and drives its bit 0. `busy_o` stays high across the boundary between the two words.
- R7: If `valid_i` is low when a word ends, or at any edge while the block is idle, then after that edge `busy_o`, `ser_o` and `last_o` are all low. No bit is sent.
- R8: Changes on `data_i` and `valid_i` after the capture edge have no effect on the bits of the word already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | WIDTH | Parallel word to send |
| valid_i | input | 1 | High when `data_i` holds a word to send |
| ser_o | output | 1 | Serial data line, registered |
| busy_o | output | 1 | High while a valid bit is on `ser_o`, registered |
| last_o | output | 1 | High while the final bit of a word is on `ser_o`, registered |

## Verification
The in-RTL assertions check the handshake relations on every cycle:
- an idle capture drives the sampled bit 0 at once;
- the end-of-word flag lasts a single cycle and only appears while busy;
- a word either chains into the next one or drops to a quiet line;
- the index counter never passes the last bit.

Only the bench's scenarios show that each bit of a word appears in the right cycle and that scrambling the input mid-word leaves the line untouched. They also show that back-to-back streams keep their bit order across word boundaries and that a reset in mid-word clears the line.

// File: rtl/ser5_pkg.sv
package ser5_pkg;

   // Width of an index able to address every bit of a word.
   function automatic int idx_width(input int w);
      return (w <= 2) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/ser5_bitcount.sv
module ser5_bitcount
   import ser5_pkg::*;
#(
   parameter int WIDTH = 5,
   localparam int IW = idx_width(WIDTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clear,
   input  logic          adv,
   output logic [IW-1:0] idx,
   output logic          at_last,
   output logic          next_last
);

   localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         idx_q <= '0;
      end else if (adv) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign idx       = idx_q;
   assign at_last   = (idx_q == LAST);
   assign next_last = (idx_q == LAST - 1'b1);

   // R3
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> idx_q <= LAST);

endmodule

// File: rtl/ser5_shifter.sv
module ser5_shifter #(
   parameter int WIDTH = 5,
   localparam int SW = WIDTH - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] din,
   output logic             head
);

   // Holds bits 1..WIDTH-1 of the captured word; position 0 is the next bit out.
   logic [SW-1:0] sr_q;

   for (genvar i = 0; i < SW; i++) begin : g_stage
      logic fill;
      if (i == SW - 1) begin : g_top
         assign fill = 1'b0;
      end else begin : g_mid
         assign fill = sr_q[i+1];
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            sr_q[i] <= 1'b0;
         end else if (load) begin
            sr_q[i] <= din[i+1];
         end else if (shift) begin
            sr_q[i] <= fill;
         end
      end
   end

   assign head = sr_q[0];

endmodule

// File: rtl/ser5_serializer.sv
module ser5_serializer
   import ser5_pkg::*;
#(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] data_i,
   input  logic             valid_i,
   output logic             ser_o,
   output logic             busy_o,
   output logic             last_o
);

   localparam int IW = idx_width(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("ser5_serializer: WIDTH must be at least 2");
   end

   logic          busy_q;
   logic          ser_q;
   logic          last_q;
   logic [IW-1:0] idx;
   logic          at_last;
   logic          next_last;
   logic          head;
   logic          slot;
   logic          take;
   logic          step;

   // A new word may start when idle or when the final bit is on the line.
   assign slot = !busy_q || at_last;
   assign take = slot && valid_i;
   assign step = busy_q && !at_last;

   ser5_bitcount #(.WIDTH(WIDTH)) u_count (
      .clk       (clk),
      .rst       (rst),
      .clear     (slot),
      .adv       (step),
      .idx       (idx),
      .at_last   (at_last),
      .next_last (next_last)
   );

   ser5_shifter #(.WIDTH(WIDTH)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .load  (take),
      .shift (step),
      .din   (data_i),
      .head  (head)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         ser_q  <= 1'b0;
         last_q <= 1'b0;
      end else begin
         busy_q <= take || step;
         ser_q  <= take ? data_i[0] : (step ? head : 1'b0);
         last_q <= step && next_last;
      end
   end

   assign ser_o  = ser_q;
   assign busy_o = busy_q;
   assign last_o = last_q;

   // R2
   idle_start_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && valid_i) |=> (busy_o && ser_o == $past(data_i[0])));

   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && !last_o) |=> busy_o);

   // R5
   last_in_word_chk: assert property (@(posedge clk) disable iff (rst)
      last_o |-> busy_o);

   // R5
   last_single_chk: assert property (@(posedge clk) disable iff (rst)
      last_o |=> !last_o);

   // R6
   chain_chk: assert property (@(posedge clk) disable iff (rst)
      (last_o && valid_i) |=> (busy_o && ser_o == $past(data_i[0])));

   // R7
   drop_chk: assert property (@(posedge clk) disable iff (rst)
      (last_o && !valid_i) |=> (!busy_o && !ser_o && !last_o));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> (!ser_o && !last_o));

   // R3
   idx_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_o |-> idx == '0);

endmodule

// File: tb/tb_ser5_serializer.sv
module tb_ser5_serializer;

   localparam int W = 5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] data_i = '0;
   logic         valid_i = 1'b0;
   logic         ser_o;
   logic         busy_o;
   logic         last_o;

   int tests = 0;
   int fails = 0;
   logic [W-1:0] q [4];

   always #10 clk = ~clk;

   ser5_serializer #(.WIDTH(W)) dut (
      .clk     (clk),
      .rst     (rst),
      .data_i  (data_i),
      .valid_i (valid_i),
      .ser_o   (ser_o),
      .busy_o  (busy_o),
      .last_o  (last_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " busy"}, int'(busy_o), 0);
      chk({tag, " ser"},  int'(ser_o),  0);
      chk({tag, " last"}, int'(last_o), 0);
   endtask

   // Sends n words from q back to back.
   // Inputs are scrambled after each capture edge to cover R8.
   task automatic stream(input int n);
      @(negedge clk);
      valid_i = 1'b1;
      data_i  = q[0];
      for (int j = 0; j < n; j++) begin
         for (int k = 0; k < W; k++) begin
            @(negedge clk);
            chk($sformatf("R4 busy w%0d b%0d", j, k), int'(busy_o), 1);
            chk($sformatf("R3 bit w%0d b%0d", j, k), int'(ser_o), int'(q[j][k]));
            chk($sformatf("R5 last w%0d b%0d", j, k), int'(last_o), (k == W-1) ? 1 : 0);
            if (k == W-1 && j + 1 < n) begin
               valid_i = 1'b1;          // R6 chain
               data_i  = q[j+1];
            end else begin
               valid_i = (k == 1);      // R8 stray valid mid-word
               data_i  = ~q[j];         // R8 scramble
            end
         end
      end
      valid_i = 1'b0;
      @(negedge clk);
      chk_idle("R7 after stream");
   endtask

   task automatic t_reset;
      valid_i = 1'b1;
      data_i  = 5'b11111;
      rst     = 1'b1;
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      valid_i = 1'b0;
      rst     = 1'b0;
      @(negedge clk);
      chk_idle("R1 after reset");
   endtask

   task automatic t_idle;
      repeat (4) begin
         @(negedge clk);
         chk_idle("R7 idle no valid");
      end
   endtask

   task automatic t_start;
      @(negedge clk);
      valid_i = 1'b1;
      data_i  = 5'b00001;
      @(negedge clk);
      valid_i = 1'b0;
      chk("R2 busy at once", int'(busy_o), 1);
      chk("R2 bit0 at once", int'(ser_o), 1);
      repeat (W) @(negedge clk);
      chk_idle("R7 after single");
   endtask

   task automatic t_mid_reset;
      @(negedge clk);
      valid_i = 1'b1;
      data_i  = 5'b11111;
      repeat (3) @(negedge clk);
      valid_i = 1'b0;
      chk("R4 busy before reset", int'(busy_o), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_idle("R1 mid-word reset");
      @(negedge clk);
      chk_idle("R1 stays idle");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      t_reset();
      t_idle();
      t_start();
      q[0] = 5'b10110;
      stream(1);
      q[0] = 5'b01011; q[1] = 5'b10000; q[2] = 5'b00111; q[3] = 5'b11001;
      stream(4);
      q[0] = 5'b11111; q[1] = 5'b00000;
      stream(2);
      t_mid_reset();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule